// File: doc/BRIEF.md
# Four-Channel DMA Request Checker and Burst Sequencer

This block holds the software-visible register set of a small group of DMA channels and stands between the devices that want to move data and the memory-side data mover. A device presents a request that names a channel, a direction and a byte length. The block accepts the request only when the sequencer is idle. It clears that channel's three status flags, then checks that the channel is switched on and that its programmed direction agrees with the request.

A request that fails the check moves no data. It raises the channel's memory-error flag, sets the channel's bit in a sticky NMI source register, and returns an error response. A request that passes is trimmed to the smaller of the requested length and the channel's remaining byte count. It is issued to the memory side as a single start pulse that carries the channel address, the trimmed length and the direction. When the memory side reports completion, the block sets the terminal-count flag, lowers the remaining count by the bytes moved, and returns a response that carries the length.

Software programs channels through a word-wide register port with combinational read data. Address translation and the data movement itself live outside this block.

Top module: `chan_dma_ctrl`

## Requirements
- R1: Channel c (0..3) owns three registers at byte offset 0x100 + c*0x20 + k*8, with address bits [1:0] ignored: k=1 is control, k=2 is remaining byte count, k=3 is address. The k=0 slot, offsets with bit 2 set, and any other unmapped offset read as zero and ignore writes. A written register reads back the written value, and every channel register is zero after reset.
- R2: In the control register, bit 0 switches the channel on and bit 1 picks the direction: 0 means device-to-memory and 1 means memory-to-device. A request's direction input uses the same encoding (1 = memory-to-device). The request passes only if bit 0 is set and bit 1 equals the request direction.
- R3: On every accepted request, bits 8 (terminal count), 9 (memory error) and 10 (address error) of that channel's control register are cleared before any new flag is set.
- R4: A request that fails the R2 check sets control bit 9 and NMI source bit c, produces no memory start, and gives a one-cycle response with the error bit set, one cycle after acceptance.
- R5: The burst length equals the smaller of the requested length and the channel's count register.
- R6: A passing request makes the memory start output pulse for exactly one cycle, one cycle after acceptance. The pulse carries the channel's address register, the R5 length and the request direction. Ready stays low from acceptance until the memory-done pulse.
- R7: On memory done, the active channel's control bit 8 is set, its count drops by the burst length, and a one-cycle response with the error bit clear and the burst length appears one cycle later.
- R8: The NMI source register reads at offset 0x200, with bit c for channel c. Writes to it have no effect, and its bits stay set until reset.
- R9: When a software write and a sequencer update hit the same register in the same cycle, the sequencer update wins and the software value is dropped.
- R10: A request presented while ready is low is ignored: no flag, NMI bit, response or memory start results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (10) | Register byte offset, for both read and write |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Combinational read data for reg_addr |
| req_valid | input | 1 | Transfer request present |
| req_chan | input | log2(NUM_CH) (2) | Requested channel |
| req_to_dev | input | 1 | 1 = memory-to-device, 0 = device-to-memory |
| req_len | input | DW (32) | Requested byte length |
| req_ready | output | 1 | Sequencer idle; a request is taken this cycle |
| mem_start | output | 1 | One-cycle burst start toward the memory side |
| mem_addr | output | DW (32) | Burst address |
| mem_len | output | DW (32) | Burst byte length |
| mem_to_dev | output | 1 | Burst direction |
| mem_done | input | 1 | Burst completion pulse from the memory side |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_err | output | 1 | Response reports a rejected request |
| resp_chan | output | log2(NUM_CH) (2) | Channel of the response |
| resp_len | output | DW (32) | Bytes moved (zero on error) |

## Verification
Every cycle, the assertions check the following: flags clear on acceptance, terminal count sets on completion, and the count drops by exactly the burst length even when software writes that register. They also check that an error response always has its NMI bit present and never comes with a memory start, that NMI bits never fall, and that requests made while busy have no effect. Some behaviours only the bench scenarios can show: the register offsets and reset values, the length trimming against the count, the address and direction carried by the burst, and the exact cycle of each response. It drives these with seeded random register programming and requests, plus directed cases for a zero count, a same-cycle write collision and a request made while busy.

// File: rtl/chan_dma_pkg.sv
// Package: shared bit positions, register indices and sequencer state
// for the DMA channel controller. Assumes 32-bit registers.
package chan_dma_pkg;
    localparam int CTRL_EN   = 0;   // channel switched on
    localparam int CTRL_DIR  = 1;   // 1 = memory-to-device
    localparam int FLAG_TC   = 8;   // terminal count reached
    localparam int FLAG_MERR = 9;   // memory / consistency error
    localparam int FLAG_AERR = 10;  // address error

    localparam int IDX_CTRL  = 1;
    localparam int IDX_COUNT = 2;
    localparam int IDX_ADDR  = 3;

    localparam int CH_REGION = 1;       // offset bits [AW-1:8] for channel space
    localparam int NMI_OFS   = 'h200;   // NMI source register offset

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_t;
endpackage

// File: rtl/chan_regs.sv
// Module: chan_regs
// Holds one channel's control, count and address registers. Software
// writes arrive as per-register strobes; sequencer updates (flag clear,
// flag set, count decrement) take priority over a software write in the
// same cycle. Assumes strobes are already decoded for this channel.
module chan_regs
    import chan_dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_count,
    input  logic          wr_addr,
    input  logic [DW-1:0] wdata,
    input  logic          clr_flags,
    input  logic          set_err,
    input  logic          set_tc,
    input  logic          dec_en,
    input  logic [DW-1:0] dec_amt,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] count_q,
    output logic [DW-1:0] addr_q
);
    logic          eng_ctrl;
    logic [DW-1:0] ctrl_eng_val;

    // Purpose: form the sequencer's view of the next control value.
    always_comb begin
        eng_ctrl     = clr_flags | set_err | set_tc;
        ctrl_eng_val = ctrl_q;
        if (clr_flags) begin
            ctrl_eng_val[FLAG_TC]   = 1'b0;
            ctrl_eng_val[FLAG_MERR] = 1'b0;
            ctrl_eng_val[FLAG_AERR] = 1'b0;
        end
        if (set_err) ctrl_eng_val[FLAG_MERR] = 1'b1;
        if (set_tc)  ctrl_eng_val[FLAG_TC]   = 1'b1;
    end

    // Purpose: control register, sequencer update before software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q <= '0;
        else if (eng_ctrl) ctrl_q <= ctrl_eng_val;
        else if (wr_ctrl)  ctrl_q <= wdata;
    end

    // Purpose: remaining byte count, decrement before software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '0;
        else if (dec_en)   count_q <= count_q - dec_amt;
        else if (wr_count) count_q <= wdata;
    end

    // Purpose: channel address register, software only.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (wr_addr) addr_q <= wdata;
    end

    // R3: a clear without a new error leaves all three flags low
    a_r3_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flags && !set_err) |=> (ctrl_q[FLAG_AERR:FLAG_TC] == 3'b000));

    // R7: completion leaves terminal count set
    a_r7_tc_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_tc |=> ctrl_q[FLAG_TC]);

    // R9: the decrement is exact even if software wrote the count that cycle
    a_r9_engine_wins: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |=> (count_q == $past(count_q) - $past(dec_amt)));
endmodule

// File: rtl/nmi_src.sv
// Module: nmi_src
// Sticky per-channel error bits. A bit sets when its channel reports a
// rejected request and clears only on reset. Assumes single-cycle set pulses.
module nmi_src #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_bits,
    output logic [NUM_CH-1:0] nmi_q
);
    // Purpose: accumulate error bits until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_q <= '0;
        else        nmi_q <= nmi_q | set_bits;
    end

    // R8: once set, a bit never falls while out of reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((nmi_q & $past(nmi_q)) == $past(nmi_q)));
endmodule

// File: rtl/xfer_seq.sv
// Module: xfer_seq
// Takes one device request at a time. It checks the request against the
// channel's control bits, then either rejects it or launches one burst,
// and it finishes the burst on the memory-done pulse. It drives per-channel
// update strobes into the register slices. Assumes NUM_CH is a power of two.
module xfer_seq
    import chan_dma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DW     = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [CH_W-1:0]            req_chan,
    input  logic                       req_to_dev,
    input  logic [DW-1:0]              req_len,
    output logic                       req_ready,
    input  logic [NUM_CH-1:0][DW-1:0]  ctrl_q,
    input  logic [NUM_CH-1:0][DW-1:0]  count_q,
    input  logic [NUM_CH-1:0][DW-1:0]  addr_q,
    output logic                       mem_start,
    output logic [DW-1:0]              mem_addr,
    output logic [DW-1:0]              mem_len,
    output logic                       mem_to_dev,
    input  logic                       mem_done,
    output logic                       resp_valid,
    output logic                       resp_err,
    output logic [CH_W-1:0]            resp_chan,
    output logic [DW-1:0]              resp_len,
    output logic [NUM_CH-1:0]          clr_flags,
    output logic [NUM_CH-1:0]          set_err,
    output logic [NUM_CH-1:0]          set_tc,
    output logic [NUM_CH-1:0]          dec_en,
    output logic [DW-1:0]              dec_amt
);
    seq_state_t      state;
    logic [CH_W-1:0] act_ch;
    logic [DW-1:0]   act_len;
    logic            accept;
    logic            sel_ok;
    logic            finish;
    logic [DW-1:0]   sel_ctrl;
    logic [DW-1:0]   sel_count;
    logic [DW-1:0]   grant_len;

    // Purpose: decode acceptance, consistency and the trimmed length.
    always_comb begin
        req_ready = (state == SEQ_IDLE);
        accept    = req_valid && req_ready;
        sel_ctrl  = ctrl_q[req_chan];
        sel_count = count_q[req_chan];
        sel_ok    = sel_ctrl[CTRL_EN] && (sel_ctrl[CTRL_DIR] == req_to_dev);
        grant_len = (req_len < sel_count) ? req_len : sel_count;
        finish    = (state == SEQ_BUSY) && mem_done;
        dec_amt   = act_len;
    end

    // Purpose: steer update strobes to the addressed channel slice.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            clr_flags[i] = accept && (req_chan == CH_W'(i));
            set_err[i]   = clr_flags[i] && !sel_ok;
            set_tc[i]    = finish && (act_ch == CH_W'(i));
            dec_en[i]    = set_tc[i];
        end
    end

    // Purpose: sequencer state and the active burst's channel and length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            act_ch  <= '0;
            act_len <= '0;
        end else if (accept && sel_ok) begin
            state   <= SEQ_BUSY;
            act_ch  <= req_chan;
            act_len <= grant_len;
        end else if (finish) begin
            state   <= SEQ_IDLE;
        end
    end

    // Purpose: registered memory-side start pulse and burst fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_start  <= 1'b0;
            mem_addr   <= '0;
            mem_len    <= '0;
            mem_to_dev <= 1'b0;
        end else begin
            mem_start <= accept && sel_ok;
            if (accept && sel_ok) begin
                mem_addr   <= addr_q[req_chan];
                mem_len    <= grant_len;
                mem_to_dev <= req_to_dev;
            end
        end
    end

    // Purpose: registered response pulse for rejections and completions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_err   <= 1'b0;
            resp_chan  <= '0;
            resp_len   <= '0;
        end else begin
            resp_valid <= (accept && !sel_ok) || finish;
            resp_err   <= accept && !sel_ok;
            resp_chan  <= accept ? req_chan : act_ch;
            resp_len   <= finish ? act_len : '0;
        end
    end

    // R4: a rejected request never launches a burst
    a_r4_no_burst_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> !mem_start);

    // R6: the start pulse lasts one cycle and ready is low while it shows
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start |-> (!req_ready ##1 !mem_start));

    // R10: a request seen while busy has no visible effect next cycle
    a_r10_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (!mem_start && !resp_err));
endmodule

// File: rtl/chan_dma_ctrl.sv
// Module: chan_dma_ctrl (top)
// Register decode and read mux for NUM_CH DMA channel slices, the sticky
// NMI source register, and the request sequencer. Channel registers sit
// at 0x100 + ch*0x20 + idx*8, so NUM_CH must not exceed 8 and AW must be
// at least 10. Read data is combinational on reg_addr.
module chan_dma_ctrl
    import chan_dma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DW     = 32,
    parameter int AW     = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [AW-1:0]               reg_addr,
    input  logic [DW-1:0]               reg_wdata,
    output logic [DW-1:0]               reg_rdata,
    input  logic                        req_valid,
    input  logic [$clog2(NUM_CH)-1:0]   req_chan,
    input  logic                        req_to_dev,
    input  logic [DW-1:0]               req_len,
    output logic                        req_ready,
    output logic                        mem_start,
    output logic [DW-1:0]               mem_addr,
    output logic [DW-1:0]               mem_len,
    output logic                        mem_to_dev,
    input  logic                        mem_done,
    output logic                        resp_valid,
    output logic                        resp_err,
    output logic [$clog2(NUM_CH)-1:0]   resp_chan,
    output logic [DW-1:0]               resp_len
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_CH-1:0][DW-1:0] ctrl_q;
    logic [NUM_CH-1:0][DW-1:0] count_q;
    logic [NUM_CH-1:0][DW-1:0] addr_q;
    logic [NUM_CH-1:0]         clr_flags;
    logic [NUM_CH-1:0]         set_err;
    logic [NUM_CH-1:0]         set_tc;
    logic [NUM_CH-1:0]         dec_en;
    logic [DW-1:0]             dec_amt;
    logic [NUM_CH-1:0]         nmi_q;

    logic [2:0]      dec_ch;
    logic [1:0]      dec_idx;
    logic            in_chan;
    logic            is_nmi;
    logic [CH_W-1:0] sel_ch;

    // Purpose: split the register offset into region, channel and index.
    always_comb begin
        dec_ch  = reg_addr[7:5];
        dec_idx = reg_addr[4:3];
        sel_ch  = dec_ch[CH_W-1:0];
        in_chan = (reg_addr[AW-1:8] == (AW-8)'(CH_REGION)) && !reg_addr[2]
                  && (int'(dec_ch) < NUM_CH);
        is_nmi  = ({reg_addr[AW-1:2], 2'b00} == AW'(NMI_OFS));
    end

    // Purpose: combinational read mux over channel and NMI registers.
    always_comb begin
        reg_rdata = '0;
        if (in_chan) begin
            case (int'(dec_idx))
                IDX_CTRL:  reg_rdata = ctrl_q[sel_ch];
                IDX_COUNT: reg_rdata = count_q[sel_ch];
                IDX_ADDR:  reg_rdata = addr_q[sel_ch];
                default:   reg_rdata = '0;
            endcase
        end else if (is_nmi) begin
            reg_rdata = {{(DW-NUM_CH){1'b0}}, nmi_q};
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic hit;
        assign hit = reg_wr && in_chan && (dec_ch == 3'(g));

        chan_regs #(.DW(DW)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctrl   (hit && (int'(dec_idx) == IDX_CTRL)),
            .wr_count  (hit && (int'(dec_idx) == IDX_COUNT)),
            .wr_addr   (hit && (int'(dec_idx) == IDX_ADDR)),
            .wdata     (reg_wdata),
            .clr_flags (clr_flags[g]),
            .set_err   (set_err[g]),
            .set_tc    (set_tc[g]),
            .dec_en    (dec_en[g]),
            .dec_amt   (dec_amt),
            .ctrl_q    (ctrl_q[g]),
            .count_q   (count_q[g]),
            .addr_q    (addr_q[g])
        );
    end

    nmi_src #(.NUM_CH(NUM_CH)) u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (set_err),
        .nmi_q    (nmi_q)
    );

    xfer_seq #(.NUM_CH(NUM_CH), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_chan   (req_chan),
        .req_to_dev (req_to_dev),
        .req_len    (req_len),
        .req_ready  (req_ready),
        .ctrl_q     (ctrl_q),
        .count_q    (count_q),
        .addr_q     (addr_q),
        .mem_start  (mem_start),
        .mem_addr   (mem_addr),
        .mem_len    (mem_len),
        .mem_to_dev (mem_to_dev),
        .mem_done   (mem_done),
        .resp_valid (resp_valid),
        .resp_err   (resp_err),
        .resp_chan  (resp_chan),
        .resp_len   (resp_len),
        .clr_flags  (clr_flags),
        .set_err    (set_err),
        .set_tc     (set_tc),
        .dec_en     (dec_en),
        .dec_amt    (dec_amt)
    );

    // R4: an error response always finds its channel's NMI bit set
    a_r4_nmi_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> nmi_q[resp_chan]);
endmodule

// File: tb/sim_chan_dma_ctrl.sv
`timescale 1ns/1ps
// Bench for chan_dma_ctrl: seeded random programming and requests plus
// directed corner cases, checked against a register model kept in the bench.
module sim_chan_dma_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [1:0]  req_chan = '0;
    logic        req_to_dev = 1'b0;
    logic [31:0] req_len = '0;
    logic        req_ready;
    logic        mem_start;
    logic [31:0] mem_addr;
    logic [31:0] mem_len;
    logic        mem_to_dev;
    logic        mem_done = 1'b0;
    logic        resp_valid;
    logic        resp_err;
    logic [1:0]  resp_chan;
    logic [31:0] resp_len;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_ctrl [4];
    logic [31:0] m_cnt  [4];
    logic [31:0] m_addr [4];
    logic [3:0]  m_nmi;

    always #2 clk = ~clk;   // 250 MHz

    chan_dma_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_chan(req_chan), .req_to_dev(req_to_dev), .req_len(req_len),
        .req_ready(req_ready), .mem_start(mem_start), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_to_dev(mem_to_dev), .mem_done(mem_done),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_chan(resp_chan),
        .resp_len(resp_len)
    );

    function automatic logic [9:0] ofs(int ch, int idx);
        return 10'(32'h100 + ch * 32'h20 + idx * 8);
    endfunction

    function automatic logic [31:0] trim(logic [31:0] want, logic [31:0] have);
        return (want < have) ? want : have;
    endfunction

    function automatic bit passes(logic [31:0] c, bit dir);
        return c[0] && (c[1] == dir);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [9:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr_chan(int ch, int idx, logic [31:0] d);
        wr(ofs(ch, idx), d);
        if (idx == 1) m_ctrl[ch] = d;
        if (idx == 2) m_cnt[ch]  = d;
        if (idx == 3) m_addr[ch] = d;
    endtask

    task automatic verify_chan(int ch);
        logic [31:0] v;
        rd(ofs(ch, 1), v); check("R3 ctrl readback", v, m_ctrl[ch]);
        rd(ofs(ch, 2), v); check("R7 count readback", v, m_cnt[ch]);
        rd(10'h200, v);    check("R8 nmi source", v, {28'b0, m_nmi});
    endtask

    // Issue one request; the memory side answers after dly cycles.
    task automatic do_req(int ch, bit dir, logic [31:0] len, int dly);
        bit ok;
        logic [31:0] glen;
        @(negedge clk);
        req_valid = 1'b1; req_chan = 2'(ch); req_to_dev = dir; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        ok = passes(m_ctrl[ch], dir);
        m_ctrl[ch] = m_ctrl[ch] & ~32'h700;
        if (!ok) begin
            m_ctrl[ch][9] = 1'b1;
            m_nmi[ch] = 1'b1;
            check("R4 resp_valid", 32'(resp_valid), 32'd1);
            check("R4 resp_err", 32'(resp_err), 32'd1);
            check("R4 resp_chan", 32'(resp_chan), 32'(ch));
            check("R4 no mem_start", 32'(mem_start), 32'd0);
        end else begin
            glen = trim(len, m_cnt[ch]);
            check("R6 mem_start", 32'(mem_start), 32'd1);
            check("R6 mem_addr", mem_addr, m_addr[ch]);
            check("R5 mem_len", mem_len, glen);
            check("R2 mem_to_dev", 32'(mem_to_dev), 32'(dir));
            check("R6 ready low", 32'(req_ready), 32'd0);
            if (dly > 0) begin
                repeat (dly) @(negedge clk);
                check("R6 pulse one cycle", 32'(mem_start), 32'd0);
                check("R6 ready held low", 32'(req_ready), 32'd0);
            end
            mem_done = 1'b1;
            @(negedge clk);
            mem_done = 1'b0;
            m_ctrl[ch][8] = 1'b1;
            m_cnt[ch] = m_cnt[ch] - glen;
            check("R7 resp_valid", 32'(resp_valid), 32'd1);
            check("R7 resp_err", 32'(resp_err), 32'd0);
            check("R7 resp_len", resp_len, glen);
            check("R7 ready back", 32'(req_ready), 32'd1);
        end
        verify_chan(ch);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int seed_sink;
        seed_sink = $urandom(32'h5EED_0042);
        for (int i = 0; i < 4; i++) begin
            m_ctrl[i] = '0; m_cnt[i] = '0; m_addr[i] = '0;
        end
        m_nmi = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int c = 0; c < 4; c++) begin
            for (int k = 1; k < 4; k++) begin
                rd(ofs(c, k), v); check("R1 reset zero", v, 32'd0);
            end
        end
        rd(10'h200, v); check("R8 nmi reset", v, 32'd0);
        check("R1 ready after reset", 32'(req_ready), 32'd1);
        check("R1 no start after reset", 32'(mem_start), 32'd0);

        // R1: readback, unused slot, bit-2 alias, unmapped
        wr_chan(1, 3, 32'hDEAD_BEE0);
        rd(ofs(1, 3), v); check("R1 addr readback", v, 32'hDEAD_BEE0);
        rd(ofs(1, 3) | 10'h3, v); check("R1 low bits ignored", v, 32'hDEAD_BEE0);
        wr(ofs(1, 0), 32'h1234_5678);
        rd(ofs(1, 0), v); check("R1 slot zero reads zero", v, 32'd0);
        wr(ofs(1, 3) | 10'h4, 32'h0BAD_0BAD);
        rd(ofs(1, 3) | 10'h4, v); check("R1 bit2 slot reads zero", v, 32'd0);
        rd(ofs(1, 3), v); check("R1 bit2 write ignored", v, 32'hDEAD_BEE0);
        wr(10'h040, 32'hFFFF_FFFF);
        rd(10'h040, v); check("R1 unmapped reads zero", v, 32'd0);

        // R2/R4: disabled channel rejected
        do_req(0, 1'b0, 32'd16, 0);
        // R2/R4: direction mismatch rejected (mode mem-to-dev, request dev-to-mem)
        wr_chan(2, 1, 32'h0000_0003);
        do_req(2, 1'b0, 32'd16, 0);
        // R8: NMI register ignores writes
        wr(10'h200, 32'h0);
        rd(10'h200, v); check("R8 nmi write ignored", v, {28'b0, m_nmi});

        // R3/R5/R7: clamp to count, then request shorter than count
        wr_chan(2, 1, 32'h0000_0702);   // stale flags + mem-to-dev, disabled
        wr_chan(2, 1, 32'h0000_0703);
        wr_chan(2, 2, 32'd100);
        wr_chan(2, 3, 32'h0001_0000);
        do_req(2, 1'b1, 32'd300, 1);
        do_req(2, 1'b1, 32'd30, 2);
        // R5: count zero gives a zero-length burst
        wr_chan(3, 1, 32'h0000_0001);
        do_req(3, 1'b0, 32'd8, 0);
        // R3: a success after an error clears the error flag
        do_req(3, 1'b1, 32'd8, 0);
        wr_chan(3, 2, 32'd8);
        do_req(3, 1'b0, 32'd8, 0);

        // R9: same-cycle software write to count loses to the decrement
        wr_chan(1, 1, 32'h0000_0001);
        wr_chan(1, 2, 32'd100);
        @(negedge clk);
        req_valid = 1'b1; req_chan = 2'd1; req_to_dev = 1'b0; req_len = 32'd40;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 start seen", 32'(mem_start), 32'd1);
        // R10: a request while busy on a disabled channel is ignored
        wr_chan(0, 1, 32'h0000_0400);
        req_valid = 1'b1; req_chan = 2'd0; req_to_dev = 1'b0; req_len = 32'd4;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 no resp while busy", 32'(resp_valid), 32'd0);
        check("R10 no start while busy", 32'(mem_start), 32'd0);
        rd(ofs(0, 1), v); check("R10 flags untouched", v, 32'h0000_0400);
        rd(10'h200, v); check("R10 nmi untouched", v, {28'b0, m_nmi});
        mem_done = 1'b1;
        reg_wr = 1'b1; reg_addr = ofs(1, 2); reg_wdata = 32'd5;
        @(negedge clk);
        mem_done = 1'b0; reg_wr = 1'b0;
        m_ctrl[1] = 32'h0000_0101;
        m_cnt[1]  = 32'd60;
        check("R9 resp_len", resp_len, 32'd40);
        verify_chan(1);

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            int ch;
            op = int'($urandom % 6);
            ch = int'($urandom % 4);
            case (op)
                0: wr_chan(ch, 1, ($urandom & 32'hFFFF_F8FC) | ($urandom % 4) |
                                  (($urandom % 2) != 0 ? 32'h1 : 32'h0));
                1: wr_chan(ch, 2, (($urandom % 3) == 0) ? $urandom : ($urandom % 200));
                2: wr_chan(ch, 3, $urandom);
                default: do_req(ch, 1'($urandom % 2),
                                (($urandom % 4) == 0) ? $urandom : ($urandom % 256),
                                int'($urandom % 4));
            endcase
        end
        for (int c = 0; c < 4; c++) begin
            verify_chan(c);
            rd(ofs(c, 3), v); check("R1 addr final", v, m_addr[c]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule